// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Pair Registers

This block computes the product or the quotient and remainder of two 32-bit operands over several clock cycles. The work is done by one bit-serial engine. It places the answer in a pair of result registers, one for the upper word (HI) and one for the lower word (LO). A caller starts an operation with a one-cycle `start` pulse. The same cycle carries a 2-bit operation code and the two operands. The caller then waits on `busy`, or on the one-cycle `done` pulse.

Multiplication adds the multiplicand into a shifting partial product once for each multiplier bit. Division is restoring: it shifts the partial remainder left, tries a subtraction of the divisor, and keeps the difference only when it does not go negative. The signed variants use the same unsigned engine. They work on operand magnitudes and fix the result signs on the last step. Both result words can be read at any time through two dedicated output ports.

Division flags no error. A zero divisor and the one overflowing signed case produce defined bit patterns, and it is up to software to screen for them.

Top module: `muldiv_seq`

## Requirements
- R1: With op = 2'b00 (unsigned multiply), the 64-bit product of `opa` and `opb` is written with bits 63:32 on `hi_out` and bits 31:0 on `lo_out`.
- R2: With op = 2'b01 (signed multiply), the operands are two's complement numbers. The 64-bit two's complement product is split the same way as in R1.
- R3: With op = 2'b10 (unsigned divide, `opa` divided by `opb`), `lo_out` receives the quotient and `hi_out` the remainder.
- R4: With op = 2'b11 (signed divide), the quotient is truncated toward zero. It goes to `lo_out`. The remainder takes the sign of the dividend and goes to `hi_out`.
- R5: An unsigned divide by zero gives a quotient of all ones and a remainder equal to the dividend. No error is raised.
- R6: When `start` is sampled high while the unit is idle, `busy` is high for exactly 32 cycles, beginning the cycle after. In the cycle after the last of them, `busy` is low, `done` is high for that single cycle, and the new result is visible on both outputs.
- R7: A `start` pulse sampled while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R8: `hi_out` and `lo_out` change only in the cycle in which `done` is high. At all other times they hold their last value.
- R9: Synchronous active-low reset clears `busy`, `done`, `hi_out` and `lo_out`.
- R10: A signed divide of -2^31 by -1 raises no error. It yields a quotient of 0x80000000 and a remainder of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; only sampled while idle |
| op | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: signed (1) or unsigned (0) |
| opa | input | 32 | Multiplicand, or dividend |
| opb | input | 32 | Multiplier, or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result registers are updated |
| hi_out | output | 32 | Upper result word: product high half, or remainder |
| lo_out | output | 32 | Lower result word: product low half, or quotient |

## Verification
The assertions assume that reset is held low for at least two clock edges before it is released. The history-based checks rely on this. They also treat `start` as meaningful only while `busy` is low. Beyond that they place no limit on operand values, so any pattern, including zero divisors and the most negative number, is legal stimulus. The bench always applies reset for several cycles. It changes inputs only on the falling clock edge and drives them from idle as well as from mid-operation, so the ignored-start case stays inside what the properties expect.

// File: rtl/muldiv_pkg.sv
// Package: shared operation encoding for the multiply/divide unit.
// Assumes a 2-bit code: bit 1 selects divide, bit 0 selects signed.
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULU = 2'b00,
        OP_MULS = 2'b01,
        OP_DIVU = 2'b10,
        OP_DIVS = 2'b11
    } md_op_e;

    // True when the code asks for a division
    function automatic logic op_is_div(input logic [1:0] code);
        return (md_op_e'(code) == OP_DIVU) || (md_op_e'(code) == OP_DIVS);
    endfunction

    // True when operands are two's complement
    function automatic logic op_is_signed(input logic [1:0] code);
        return (md_op_e'(code) == OP_MULS) || (md_op_e'(code) == OP_DIVS);
    endfunction

endpackage

// File: rtl/muldiv_prep.sv
// Module: operand conditioning. Turns both operands into magnitudes when
// a signed operation is requested and reports which results need negating.
// Assumes: purely combinational, sampled by the caller on the start cycle.
module muldiv_prep #(
    parameter int W = 32
) (
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         neg_main,
    output logic         neg_rem
);
    logic a_neg;
    logic b_neg;

    // Derive magnitudes and result sign flags
    always_comb begin
        a_neg    = sgn & a[W-1];
        b_neg    = sgn & b[W-1];
        a_mag    = a_neg ? (~a + 1'b1) : a;
        b_mag    = b_neg ? (~b + 1'b1) : b;
        neg_main = a_neg ^ b_neg;
        neg_rem  = a_neg;
    end
endmodule

// File: rtl/muldiv_core.sv
// Module: bit-serial engine shared by multiply and divide. Holds a 2W-bit
// working register and a W-bit operand register.
// Multiply: upper half accumulates, lower half holds the multiplier and
// shifts right one bit per step.
// Divide (restoring): upper half is the partial remainder, lower half
// shifts the dividend out and the quotient in.
// Assumes: load and step are never both high; W steps finish an operation.
module muldiv_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           div_sel,
    input  logic [W-1:0]   a_mag,
    input  logic [W-1:0]   b_mag,
    output logic [2*W-1:0] work_nxt
);
    logic [2*W-1:0] work;
    logic [W-1:0]   opnd;
    logic           div_q;
    logic [W:0]     acc_sum;
    logic [W:0]     rem_shift;
    logic [W:0]     rem_diff;
    logic           fits;
    logic [W-1:0]   rem_new;

    // One iteration of either algorithm, chosen by the latched mode
    always_comb begin
        acc_sum   = {1'b0, work[2*W-1:W]} + (work[0] ? {1'b0, opnd} : '0);
        rem_shift = {work[2*W-1:W], work[W-1]};
        rem_diff  = rem_shift - {1'b0, opnd};
        fits      = ~rem_diff[W];
        rem_new   = fits ? rem_diff[W-1:0] : rem_shift[W-1:0];
        if (div_q) begin
            work_nxt = {rem_new, work[W-2:0], fits};
        end else begin
            work_nxt = {acc_sum, work[W-1:1]};
        end
    end

    // Load operands on start, advance one step per busy cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work  <= '0;
            opnd  <= '0;
            div_q <= 1'b0;
        end else if (load) begin
            div_q <= div_sel;
            work  <= {{W{1'b0}}, (div_sel ? a_mag : b_mag)};
            opnd  <= div_sel ? b_mag : a_mag;
        end else if (step) begin
            work  <= work_nxt;
        end
    end
endmodule

// File: rtl/muldiv_fix.sv
// Module: result sign correction. Negates the full product, or the
// quotient and remainder separately, as the latched flags demand.
// Assumes: flags stay constant for the whole operation.
module muldiv_fix #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] res,
    input  logic           is_div,
    input  logic           neg_main,
    input  logic           neg_rem,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);
    logic [2*W-1:0] prod;

    // Apply signs to the raw unsigned result
    always_comb begin
        prod = neg_main ? (~res + 1'b1) : res;
        if (is_div) begin
            lo = neg_main ? (~res[W-1:0] + 1'b1) : res[W-1:0];
            hi = neg_rem ? (~res[2*W-1:W] + 1'b1) : res[2*W-1:W];
        end else begin
            lo = prod[W-1:0];
            hi = prod[2*W-1:W];
        end
    end
endmodule

// File: rtl/muldiv_seq.sv
// Module: top of the iterative multiply/divide unit. Accepts a start
// pulse while idle, runs W iterations, then writes HI/LO and pulses done.
// Assumes: op/opa/opb are valid in the cycle start is sampled; a start
// seen while busy is dropped.
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out
);
    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic           accept;
    logic [CW-1:0]  step_cnt;
    logic           div_r;
    logic           neg_main_r;
    logic           neg_rem_r;
    logic [W-1:0]   a_mag;
    logic [W-1:0]   b_mag;
    logic           neg_main_c;
    logic           neg_rem_c;
    logic [2*W-1:0] work_nxt;
    logic [W-1:0]   fix_hi;
    logic [W-1:0]   fix_lo;

    assign accept = start & ~busy;

    muldiv_prep #(.W(W)) u_prep (
        .sgn      (op_is_signed(op)),
        .a        (opa),
        .b        (opb),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .neg_main (neg_main_c),
        .neg_rem  (neg_rem_c)
    );

    muldiv_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (busy),
        .div_sel  (op_is_div(op)),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .work_nxt (work_nxt)
    );

    muldiv_fix #(.W(W)) u_fix (
        .res      (work_nxt),
        .is_div   (div_r),
        .neg_main (neg_main_r),
        .neg_rem  (neg_rem_r),
        .hi       (fix_hi),
        .lo       (fix_lo)
    );

    // Sequence control, sign flag capture and result register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            step_cnt   <= '0;
            div_r      <= 1'b0;
            neg_main_r <= 1'b0;
            neg_rem_r  <= 1'b0;
            hi_out     <= '0;
            lo_out     <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy       <= 1'b1;
                step_cnt   <= '0;
                div_r      <= op_is_div(op);
                neg_main_r <= neg_main_c;
                neg_rem_r  <= neg_rem_c;
            end else if (busy) begin
                step_cnt <= step_cnt + 1'b1;
                if (step_cnt == LAST) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    hi_out <= fix_hi;
                    lo_out <= fix_lo;
                end
            end
        end
    end
endmodule

// File: rtl/muldiv_seq_chk.sv
// Module: protocol checker for muldiv_seq, attached with bind.
// Assumes reset is held low for at least two edges before release.
module muldiv_seq_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    localparam int RW = $clog2(W) + 2;

    logic [RW-1:0] run;

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else begin
            run <= busy ? run + 1'b1 : '0;
        end
    end

    // R6: busy lasts exactly W cycles
    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == RW'(W)));

    // R6: end of busy comes with done
    assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: done is a single-cycle pulse outside busy
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)) ##1 !done);

    // R7: busy only begins after a start request
    assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8: result words hold outside the done cycle
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo)));
endmodule

bind muldiv_seq muldiv_seq_chk #(.W(W)) u_muldiv_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .hi    (hi_out),
    .lo    (lo_out)
);

// File: tb/test_muldiv_seq.sv
// Bench: behavioural cycle model of the unit, compared on every falling edge,
// plus direct end-of-operation checks of HI/LO per requirement.
module test_muldiv_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic        done;
    logic [31:0] hi_out;
    logic [31:0] lo_out;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    string cur_req = "R9";

    // model state
    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    int          m_cnt  = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;
    logic [31:0] p_hi = '0;
    logic [31:0] p_lo = '0;

    always #10 clk = ~clk;

    muldiv_seq i_muldiv_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .busy   (busy),
        .done   (done),
        .hi_out (hi_out),
        .lo_out (lo_out)
    );

    // expected result from the requirements
    task automatic ref_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] h, output logic [31:0] l);
        longint      sa;
        longint      sb;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p  = '0;
        case (o)
            2'b00: begin p = {32'b0, a} * {32'b0, b}; h = p[63:32]; l = p[31:0]; end
            2'b01: begin p = 64'(sa * sb); h = p[63:32]; l = p[31:0]; end
            2'b10: begin
                if (b == 0) begin h = a; l = '1; end
                else begin h = a % b; l = a / b; end
            end
            default: begin
                if (b == 0) begin h = a; l = (sa < 0) ? 32'd1 : '1; end
                else begin h = 32'(sa % sb); l = 32'(sa / sb); end
            end
        endcase
    endtask

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // reference model: one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_hi = '0; m_lo = '0;
        end else begin
            m_done = 1'b0;
            if (!m_busy && start) begin
                m_busy = 1'b1;
                m_cnt  = 1;
                ref_op(op, opa, opb, p_hi, p_lo);
            end else if (m_busy) begin
                if (m_cnt == 32) begin
                    m_busy = 1'b0; m_done = 1'b1; m_hi = p_hi; m_lo = p_lo;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (mon_en) begin
            check("R6", "busy", {31'b0, busy}, {31'b0, m_busy});
            check("R6", "done", {31'b0, done}, {31'b0, m_done});
            check(cur_req, "hi (cycle, R8)", hi_out, m_hi);
            check(cur_req, "lo (cycle, R8)", lo_out, m_lo);
        end
    end

    task automatic wait_done();
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic run_op(input string req, input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] eh;
        logic [31:0] el;
        @(negedge clk);
        cur_req = req;
        op = o; opa = a; opb = b; start = 1'b1;
        ref_op(o, a, b, eh, el);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(req, "done seen", {31'b0, done}, 32'd1);
        check(req, "hi", hi_out, eh);
        check(req, "lo", lo_out, el);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] eh;
        logic [31:0] el;
        repeat (2) @(negedge clk);
        mon_en = 1'b1;                      // R9: reset values compared by monitor
        repeat (3) @(negedge clk);
        check("R9", "busy in reset", {31'b0, busy}, 32'd0);
        check("R9", "hi in reset", hi_out, 32'd0);
        rst_n = 1'b1;

        run_op("R1", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R1", 2'b00, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op("R1", 2'b00, 32'h0000_0000, 32'hDEAD_BEEF);
        run_op("R2", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R2", 2'b01, 32'hFFFF_FFF9, 32'h0000_0003);
        run_op("R2", 2'b01, 32'h8000_0000, 32'h8000_0000);
        run_op("R2", 2'b01, 32'h0000_0005, 32'hFFFF_FFFF);
        run_op("R3", 2'b10, 32'd100, 32'd7);
        run_op("R3", 2'b10, 32'hFFFF_FFFF, 32'h0000_0010);
        run_op("R3", 2'b10, 32'd5, 32'd9);
        run_op("R4", 2'b11, 32'hFFFF_FFF9, 32'd2);
        run_op("R4", 2'b11, 32'd7, 32'hFFFF_FFFE);
        run_op("R4", 2'b11, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
        run_op("R5", 2'b10, 32'd1234, 32'd0);
        run_op("R10", 2'b11, 32'h8000_0000, 32'hFFFF_FFFF);

        // R7: start pulse mid-operation with different operands is dropped
        @(negedge clk);
        cur_req = "R7";
        op = 2'b00; opa = 32'd6; opb = 32'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op = 2'b10; opa = 32'd99; opb = 32'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R7", "hi after ignored start", hi_out, 32'd0);
        check("R7", "lo after ignored start", lo_out, 32'd42);

        // R6: a new start accepted in the done cycle itself
        cur_req = "R6";
        op = 2'b10; opa = 32'd50; opb = 32'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6", "busy after back-to-back start", {31'b0, busy}, 32'd1);
        wait_done();
        check("R6", "hi back-to-back", hi_out, 32'd2);
        check("R6", "lo back-to-back", lo_out, 32'd6);

        // R8: idle with changing inputs and no start leaves results alone
        cur_req = "R8";
        for (int k = 0; k < 6; k++) begin
            op = 2'(k); opa = 32'(k * 77); opb = 32'(k + 3);
            @(negedge clk);
        end
        ref_op(2'b10, 32'd50, 32'd8, eh, el);
        check("R8", "hi held", hi_out, eh);
        check("R8", "lo held", lo_out, el);

        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule